// File: doc/BRIEF.md
# Two-Strobe Parallel Configuration Loader

This block writes one 32-bit configuration value into an external converter whose parallel data bus is only 16 bits wide. A host gives it a one-cycle start request together with the word. The block then makes two write accesses on the bus: the upper half goes first and the lower half second. When the second access has finished, it returns a one-cycle completion pulse. The converter latches bus data only while its active-low select and its active-low write strobe are both low. The block therefore drives both lines, the bus, and a separate bus enable that lets the pads go high-impedance while no access is running.

A mode input, sampled with the start request, sets how the select line behaves. In held mode the select stays low through both accesses. In per-access mode the select falls together with each write strobe and rises one clock after it. In both modes the strobe rises before the select does. The data setup time, the strobe low time and the minimum strobe high time between the two accesses are parameters counted in system clocks. There is no readback path, because the register cannot be read over this bus.

Top module: `cfg_word_writer`

## Requirements
- R1: After reset, and whenever the block is idle, cs_n_o=1, wr_n_o=1, bus_oe_o=0, bus_o=0, busy_o=0 and done_o=0.
- R2: A start_i seen at a clock edge while idle begins a transfer. The upper half word_i[31:16] is sent in the first access and the lower half word_i[15:0] in the second.
- R3: For the first access, bus_oe_o=1 and bus_o carries the upper half for exactly SETUP_CYC cycles with wr_n_o=1 before wr_n_o falls. This setup phase starts in the first cycle after the start edge.
- R4: In each access wr_n_o stays low for exactly LOW_CYC cycles, and bus_o does not change while wr_n_o is low.
- R5: Between the two accesses wr_n_o stays high for exactly 1+max(SETUP_CYC, HIGH_CYC-1) cycles, which is never fewer than HIGH_CYC. The lower half is driven throughout the setup part of that gap.
- R6: Held mode (hold_cs_i=1 at the start edge): cs_n_o is low without a break from the first cycle after the start edge to the last cycle of the transfer.
- R7: Per-access mode (hold_cs_i=0 at the start edge): cs_n_o is low exactly in the cycles where wr_n_o is low and in the one cycle after each of them.
- R8: After each strobe rises, the bus keeps its value and stays enabled for one more cycle. At the end of a transfer wr_n_o rises one cycle before cs_n_o rises.
- R9: done_o is high for exactly one cycle, the first cycle after the final access. busy_o is high from the first cycle after the start edge up to that cycle and low in it.
- R10: start_i, word_i and hold_cs_i have no effect while busy_o=1. No second transfer follows, and the transfer in progress keeps the word and mode captured at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acted on only when idle |
| word_i | input | 32 | Configuration value to write |
| hold_cs_i | input | 1 | 1 = select held low across both accesses, 0 = select per access |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| wr_n_o | output | 1 | Active-low write strobe to the converter |
| bus_o | output | 16 | Data driven onto the parallel bus |
| bus_oe_o | output | 1 | High while the block drives the bus |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with SETUP_CYC=2, LOW_CYC=3 and HIGH_CYC=5. With these values the minimum high time, not the setup count, sets the length of the gap between the two strobes, so the second setup phase (4 cycles) is longer than the first (2 cycles). Any error in how that gap is lengthened shows up as a shifted strobe. Every cycle of every transfer is compared against an expected timeline, in both select modes. This covers words with only one half set, and start requests that arrive at random points of a transfer, including its last busy cycle.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } cfgw_state_e;
endpackage

// File: rtl/cfgw_down_timer.sv
module cfgw_down_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfgw_bus_mux.sv
module cfgw_bus_mux #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word_i,
    input  logic                sel_lo_i,
    input  logic                en_i,
    output logic [HALF_W-1:0]   bus_o
);
    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        assign bus_o[i] = en_i & (sel_lo_i ? word_i[i] : word_i[i+HALF_W]);
    end
endmodule

// File: rtl/cfg_word_writer.sv
module cfg_word_writer
    import cfgw_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int SETUP_CYC = 2,
    parameter int LOW_CYC   = 3,
    parameter int HIGH_CYC  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2*HALF_W-1:0] word_i,
    input  logic                hold_cs_i,
    output logic                cs_n_o,
    output logic                wr_n_o,
    output logic [HALF_W-1:0]   bus_o,
    output logic                bus_oe_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int SET2   = (SETUP_CYC > HIGH_CYC - 1) ? SETUP_CYC : HIGH_CYC - 1;
    localparam int MAXC   = (SET2 > LOW_CYC) ? SET2 : LOW_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] LD_SET1 = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_SET2 = CNT_W'(SET2 - 1);
    localparam logic [CNT_W-1:0] LD_LOW  = CNT_W'(LOW_CYC - 1);

    typedef struct packed {
        cfgw_state_e       state;
        logic              second;
        logic              hold;
        logic [WORD_W-1:0] word;
        logic              done;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             active;

    cfgw_down_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state  = ST_SETUP;
                    ctl_d.second = 1'b0;
                    ctl_d.hold   = hold_cs_i;
                    ctl_d.word   = word_i;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_SET1;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    ctl_d.state = ST_STROBE;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_LOW;
                end
            end
            ST_STROBE: begin
                if (tmr_zero) ctl_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (!ctl_q.second) begin
                    ctl_d.state  = ST_SETUP;
                    ctl_d.second = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_SET2;
                end else begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, second: 1'b0, hold: 1'b0, word: '0, done: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign active   = (ctl_q.state != ST_IDLE);
    assign wr_n_o   = (ctl_q.state != ST_STROBE);
    assign cs_n_o   = ctl_q.hold ? !active
                                 : !((ctl_q.state == ST_STROBE) || (ctl_q.state == ST_HOLD));
    assign bus_oe_o = active;
    assign busy_o   = active;
    assign done_o   = ctl_q.done;

    cfgw_bus_mux #(.HALF_W(HALF_W)) u_mux (
        .word_i   (ctl_q.word),
        .sel_lo_i (ctl_q.second),
        .en_i     (active),
        .bus_o    (bus_o)
    );

    // Run-length counters used only by the checks below
    logic [15:0] low_run_q, high_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            high_run_q <= '0;
        end else begin
            low_run_q  <= wr_n_o ? 16'd0 : low_run_q + 16'd1;
            high_run_q <= (wr_n_o && busy_o) ? high_run_q + 16'd1 : 16'd0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && wr_n_o && !bus_oe_o && bus_o == '0));
    p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> low_run_q == 16'(LOW_CYC));
    p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o && !$past(wr_n_o)) |-> $stable(bus_o));
    p_gap_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n_o) && ctl_q.second) |-> high_run_q >= 16'(HIGH_CYC));
    p_cs_covers_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (!cs_n_o && bus_oe_o));
    p_wr_before_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> $past(wr_n_o));
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(ctl_q.state == ST_HOLD && ctl_q.second)) |=> busy_o && $stable(ctl_q.word));
endmodule

// File: tb/sim_cfg_word_writer.sv
module sim_cfg_word_writer;
    localparam int S  = 2;
    localparam int L  = 3;
    localparam int H  = 5;
    localparam int S2 = (S > H - 1) ? S : H - 1;
    localparam int T  = 2 * L + S + S2 + 2;

    typedef struct packed {
        logic        cs_n;
        logic        wr_n;
        logic        oe;
        logic        busy;
        logic        done;
        logic [15:0] bus;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        hold_cs_i = 1'b0;
    logic        cs_n_o, wr_n_o, bus_oe_o, busy_o, done_o;
    logic [15:0] bus_o;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    cfg_word_writer #(.HALF_W(16), .SETUP_CYC(S), .LOW_CYC(L), .HIGH_CYC(H)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
        .hold_cs_i(hold_cs_i), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .bus_o(bus_o),
        .bus_oe_o(bus_oe_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic obs_t idle_obs(bit done);
        obs_t o;
        o = '{cs_n: 1'b1, wr_n: 1'b1, oe: 1'b0, busy: 1'b0, done: done, bus: 16'h0};
        return o;
    endfunction

    // Expected outputs k cycles after the start edge (R2..R9)
    function automatic obs_t exp_at(int k, bit hold, logic [31:0] w);
        obs_t o;
        int   a2;
        a2 = S + L + 1;
        if (k >= T) return idle_obs(k == T);
        o.busy = 1'b1;
        o.done = 1'b0;
        o.oe   = 1'b1;
        o.bus  = (k < a2) ? w[31:16] : w[15:0];
        if (k < S || (k >= a2 && k < a2 + S2)) begin
            o.wr_n = 1'b1;
            o.cs_n = !hold;
        end else if (k == S + L || k == T - 1) begin
            o.wr_n = 1'b1;
            o.cs_n = 1'b0;
        end else begin
            o.wr_n = 1'b0;
            o.cs_n = 1'b0;
        end
        return o;
    endfunction

    function automatic obs_t sample();
        obs_t o;
        o = '{cs_n: cs_n_o, wr_n: wr_n_o, oe: bus_oe_o, busy: busy_o, done: done_o, bus: bus_o};
        return o;
    endfunction

    task automatic check(string req, obs_t exp);
        obs_t act;
        act = sample();
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual cs=%b wr=%b oe=%b busy=%b done=%b bus=%h expected cs=%b wr=%b oe=%b busy=%b done=%b bus=%h",
                     req, $time, act.cs_n, act.wr_n, act.oe, act.busy, act.done, act.bus,
                     exp.cs_n, exp.wr_n, exp.oe, exp.busy, exp.done, exp.bus);
        end
    endtask

    // One transfer; inj >= 0 sends a stray start at that offset (R10)
    task automatic transfer(logic [31:0] w, bit hold, int inj);
        @(negedge clk);
        start_i   = 1'b1;
        word_i    = w;
        hold_cs_i = hold;
        @(negedge clk);
        for (int k = 0; k <= T + 1; k++) begin
            check(hold ? "R2/R3/R4/R5/R6/R8/R9" : "R2/R3/R4/R5/R7/R8/R9", exp_at(k, hold, w));
            if (k == inj) begin
                start_i   = 1'b1;
                word_i    = ~w;
                hold_cs_i = !hold;
            end else begin
                start_i   = 1'b0;
            end
            if (k < T + 1) @(negedge clk);
        end
        if (inj >= 0) check("R10 stray start ignored", idle_obs(1'b0));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset", idle_obs(1'b0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", idle_obs(1'b0));
        transfer(32'hFFFF_0000, 1'b1, -1);
        transfer(32'h0000_FFFF, 1'b0, -1);
        transfer(32'hA5C3_3C5A, 1'b1, T - 1);
        transfer(32'h1234_5678, 1'b0, 0);
        for (int i = 0; i < 24; i++) begin
            logic [31:0] w;
            bit          hold;
            int          inj;
            w    = $urandom();
            hold = $urandom() % 2;
            inj  = ($urandom() % 2) ? int'($urandom() % T) : -1;
            transfer(w, hold, inj);
            repeat ($urandom() % 3) begin
                @(negedge clk);
                check("R1 idle between transfers", idle_obs(1'b0));
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule